// File: doc/BRIEF.md
# Atom Lookup Buffer

This block is a small translation cache that maps physical address regions onto atom identifiers. With it, metadata lookups can skip the walk of the mapping table that is held in memory. Any physical address presented on the lookup port is reduced to a region tag by dropping its low `GRAN_LOG2` bits. The tag is compared against the stored entries, and the block returns a hit flag together with the atom id of the matching entry. The block does all of this in the same cycle.

A miss handler elsewhere in the chip writes new mappings through the fill port. A single invalidate input empties the buffer in one cycle. In the default build the buffer is fully associative. A fill first reuses an entry that already holds the same tag, then takes the lowest-numbered free entry, and only when every entry is valid does it evict a pseudo-random victim picked by an 8-bit LFSR. Setting `DIRECT_MAPPED` to 1 gives a direct-mapped buffer instead, in which the low tag bits pick the single entry a region may occupy.

Top module: `atom_lookup_buf`

## Requirements
- R1: The lookup outputs are combinational from `lk_addr` and the stored state. Any two addresses with equal bits `[ADDR_W-1:GRAN_LOG2]` give the same result.
- R2: After reset no entry is valid, so every lookup returns `lk_hit`=0 and `lk_id`=0.
- R3: A fill that is not accompanied by `flush` becomes visible to lookups from the cycle after the fill edge. On a hit `lk_id` equals the filled id. On a miss `lk_id` is 0.
- R4: A fill whose region tag is already stored overwrites that entry's id and allocates no second entry.
- R5: In the fully-associative build, a fill of a new tag while any entry is invalid evicts no stored mapping, so `ENTRIES` distinct tags all stay resident.
- R6: In the fully-associative build, a fill of a new tag while all entries are valid replaces exactly one stored mapping.
- R7: The victim for R6 is taken from an 8-bit maximal-length LFSR (taps 8,6,5,4). The LFSR advances on every cycle out of reset and never holds zero.
- R8: `flush` clears every valid bit at the next edge. A fill in the same cycle as `flush` is dropped.
- R9: With `DIRECT_MAPPED`=1, tag bits `[IDX_W-1:0]` select the only entry a region can use. A fill to an occupied index replaces that index's previous mapping and leaves other indices untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Physical address to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_id | output | ID_W | Atom id of the matching entry, 0 on a miss |
| fill_en | input | 1 | Write a mapping this cycle |
| fill_addr | input | ADDR_W | Physical address whose region is being mapped |
| fill_id | input | ID_W | Atom id to store |
| flush | input | 1 | Invalidate all entries |

## Verification
The checker watches several properties on every cycle. The stored table must never hold the same tag twice, and an invalidate must leave no valid entry and no hit. The LFSR must step and stay non-zero. In the associative build, a fill of a new tag must grow the occupancy by one while free entries remain. Which mapping is evicted once the buffer is full, that exactly one is lost, and how addresses within one granule alias can only be shown by the bench's scenarios, which probe every previously filled region through the lookup port. The same applies to index conflicts in the direct-mapped build.

// File: rtl/alb_pkg.sv
`timescale 1ns/1ps
package alb_pkg;
    localparam int LFSR_W = 8;

    // x^8 + x^6 + x^5 + x^4 + 1, Fibonacci form, maximal length
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction
endpackage

// File: rtl/alb_lfsr.sv
`timescale 1ns/1ps
module alb_lfsr
    import alb_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [LFSR_W-1:0] state
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_step(lfsr_q);
        if (lfsr_d == '0) lfsr_d = SEED;  // guard, unreachable from a non-zero seed
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= (SEED == '0) ? 8'h01 : SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;
endmodule

// File: rtl/alb_match.sv
`timescale 1ns/1ps
module alb_match #(
    parameter int ENTRIES       = 8,
    parameter int TAG_W         = 28,
    parameter bit DIRECT_MAPPED = 1'b0,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tag_tbl,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);
    logic [IDX_W-1:0] key_idx;
    assign key_idx = key[IDX_W-1:0];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        if (DIRECT_MAPPED) begin : g_dm
            assign match[e] = valid[e] && (key_idx == IDX_W'(e)) && (tag_tbl[e] == key);
        end else begin : g_fa
            assign match[e] = valid[e] && (tag_tbl[e] == key);
        end
    end
endmodule

// File: rtl/alb_victim.sv
`timescale 1ns/1ps
module alb_victim
    import alb_pkg::*;
#(
    parameter int ENTRIES       = 8,
    parameter bit DIRECT_MAPPED = 1'b0,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] hit_vec,
    input  logic [IDX_W-1:0]   key_idx,
    input  logic [LFSR_W-1:0]  rnd,
    output logic [IDX_W-1:0]   victim
);
    if (DIRECT_MAPPED) begin : g_dm
        assign victim = key_idx;
    end else begin : g_fa
        logic [IDX_W-1:0] hit_idx, free_idx;
        logic             any_hit, any_free;

        always_comb begin
            hit_idx  = '0;
            free_idx = '0;
            any_hit  = 1'b0;
            any_free = 1'b0;
            for (int e = ENTRIES - 1; e >= 0; e--) begin
                if (hit_vec[e]) begin
                    hit_idx = IDX_W'(e);
                    any_hit = 1'b1;
                end
                if (!valid[e]) begin
                    free_idx = IDX_W'(e);
                    any_free = 1'b1;
                end
            end
        end

        always_comb begin
            if (any_hit)       victim = hit_idx;
            else if (any_free) victim = free_idx;
            else               victim = rnd[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/atom_lookup_buf.sv
`timescale 1ns/1ps
module atom_lookup_buf
    import alb_pkg::*;
#(
    parameter int  ADDR_W        = 40,
    parameter int  GRAN_LOG2     = 12,
    parameter int  ID_W          = 8,
    parameter int  ENTRIES       = 8,
    parameter bit  DIRECT_MAPPED = 1'b0,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [ID_W-1:0]   lk_id,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ID_W-1:0]   fill_id,
    input  logic              flush
);
    localparam int TAG_W = ADDR_W - GRAN_LOG2;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][ID_W-1:0]  id;
    } tbl_t;

    tbl_t st_d, st_q;

    logic [TAG_W-1:0]   lk_tag, fill_tag;
    logic [ENTRIES-1:0] lk_match, fill_match, valid_vec;
    logic               fill_hit;
    logic [LFSR_W-1:0]  lfsr_q;
    logic [IDX_W-1:0]   victim_w;

    assign lk_tag    = lk_addr[ADDR_W-1:GRAN_LOG2];
    assign fill_tag  = fill_addr[ADDR_W-1:GRAN_LOG2];
    assign valid_vec = st_q.valid;

    alb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DIRECT_MAPPED(DIRECT_MAPPED)) u_lk_match (
        .tag_tbl(st_q.tag), .valid(st_q.valid), .key(lk_tag), .match(lk_match)
    );

    alb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DIRECT_MAPPED(DIRECT_MAPPED)) u_fill_match (
        .tag_tbl(st_q.tag), .valid(st_q.valid), .key(fill_tag), .match(fill_match)
    );

    assign fill_hit = |fill_match;

    alb_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .state(lfsr_q)
    );

    alb_victim #(.ENTRIES(ENTRIES), .DIRECT_MAPPED(DIRECT_MAPPED)) u_victim (
        .valid(st_q.valid), .hit_vec(fill_match), .key_idx(fill_tag[IDX_W-1:0]),
        .rnd(lfsr_q), .victim(victim_w)
    );

    // lookup result: at most one entry matches, so an OR-reduce selects it
    always_comb begin
        lk_hit = |lk_match;
        lk_id  = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            lk_id = lk_id | (st_q.id[e] & {ID_W{lk_match[e]}});
        end
    end

    // next table state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_en) begin
            st_d.valid[victim_w] = 1'b1;
            st_d.tag[victim_w]   = fill_tag;
            st_d.id[victim_w]    = fill_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/alb_checker.sv
`timescale 1ns/1ps
module alb_checker #(
    parameter int ENTRIES       = 8,
    parameter bit DIRECT_MAPPED = 1'b0,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               fill_en,
    input logic               fill_hit,
    input logic               lk_hit,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] fill_match,
    input logic [IDX_W-1:0]   victim,
    input logic [7:0]         lfsr_q
);
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    assert_flush_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    assert_no_duplicate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match));

    assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> valid_q[$past(victim)]);

    assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 8'h00);

    assert_lfsr_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lfsr_q != $past(lfsr_q)));

    if (!DIRECT_MAPPED) begin : g_fa
        assert_free_slot_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (fill_en && !flush && !fill_hit && !(&valid_q))
            |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
    end
endmodule

bind atom_lookup_buf alb_checker #(.ENTRIES(ENTRIES), .DIRECT_MAPPED(DIRECT_MAPPED)) chk_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en), .fill_hit(fill_hit),
    .lk_hit(lk_hit), .valid_q(valid_vec), .fill_match(fill_match), .victim(victim_w),
    .lfsr_q(lfsr_q)
);

// File: tb/atom_lookup_buf_tb_top.sv
`timescale 1ns/1ps
module atom_lookup_buf_tb_top;
    localparam int ADDR_W = 40;
    localparam int ID_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [ID_W-1:0]   fill_id = '0;
    logic              fill_en = 1'b0;
    logic              flush = 1'b0;
    logic              fa_hit, dm_hit;
    logic [ID_W-1:0]   fa_id, dm_id;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;  // 50 MHz

    atom_lookup_buf dut_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(fa_hit), .lk_id(fa_id),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_id(fill_id), .flush(flush)
    );

    atom_lookup_buf #(.DIRECT_MAPPED(1'b1)) dut_dm_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(dm_hit), .lk_id(dm_id),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_id(fill_id), .flush(flush)
    );

    // op: 0 lookup, 1 fill, 2 flush
    typedef struct packed {
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
        logic              ehit;
        logic [ID_W-1:0]   eid;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 40'h00_0000_1000, 8'd0, 1'b0, 8'd0},  // R2 empty
        '{2'd1, 40'h00_0000_1000, 8'd5, 1'b0, 8'd0},
        '{2'd0, 40'h00_0000_1abc, 8'd0, 1'b1, 8'd5},  // R1 same granule
        '{2'd0, 40'h00_0000_2000, 8'd0, 1'b0, 8'd0},  // R3 miss id 0
        '{2'd1, 40'h00_0000_2000, 8'd9, 1'b0, 8'd0},
        '{2'd0, 40'h00_0000_2fff, 8'd0, 1'b1, 8'd9},  // R3 hit
        '{2'd1, 40'h00_0000_1000, 8'd7, 1'b0, 8'd0},  // R4 overwrite
        '{2'd0, 40'h00_0000_1000, 8'd0, 1'b1, 8'd7},  // R4
        '{2'd0, 40'h00_0000_2000, 8'd0, 1'b1, 8'd9},  // R4 other kept
        '{2'd2, 40'h00_0000_0000, 8'd0, 1'b0, 8'd0},
        '{2'd0, 40'h00_0000_1000, 8'd0, 1'b0, 8'd0},  // R8
        '{2'd0, 40'h00_0000_2000, 8'd0, 1'b0, 8'd0}   // R8
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [ADDR_W-1:0] a, input logic [ID_W-1:0] id);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a; fill_id = id;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input bit dm,
                         output logic hit, output logic [ID_W-1:0] id);
        @(negedge clk);
        lk_addr = a;
        #2;
        hit = dm ? dm_hit : fa_hit;
        id  = dm ? dm_id  : fa_id;
    endtask

    task automatic expect_lk(input string req, input logic [ADDR_W-1:0] a, input bit dm,
                             input logic ehit, input logic [ID_W-1:0] eid);
        logic h;
        logic [ID_W-1:0] i;
        probe(a, dm, h, i);
        chk(req, 64'(h), 64'(ehit));
        chk(req, 64'(i), 64'(eid));
    endtask

    task automatic count_hits(input int base, input int n, output int hits);
        logic h;
        logic [ID_W-1:0] i;
        hits = 0;
        for (int k = 0; k < n; k++) begin
            probe(40'h00_0010_0000 + ADDR_W'(k + base) * 40'h1000, 1'b0, h, i);
            if (h) hits++;
        end
    endtask

    initial begin : watchdog
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int hits;
        logic h;
        logic [ID_W-1:0] i;
        repeat (3) @(negedge clk);
        // R2 reset state on both organisations
        expect_lk("R2", 40'h0, 1'b0, 1'b0, 8'd0);
        expect_lk("R2", 40'h0, 1'b1, 1'b0, 8'd0);
        rst_n = 1'b1;
        expect_lk("R2", 40'h0, 1'b0, 1'b0, 8'd0);

        for (int v = 0; v < NV; v++) begin
            case (VECS[v].op)
                2'd1: do_fill(VECS[v].addr, VECS[v].id);
                2'd2: do_flush();
                default: expect_lk($sformatf("R1 R3 R4 R8 vec%0d", v), VECS[v].addr, 1'b0,
                                   VECS[v].ehit, VECS[v].eid);
            endcase
        end

        // R4 + R5: refill of one tag then seven more distinct tags -> eight resident
        do_fill(40'h00_0010_0000, 8'h20);
        do_fill(40'h00_0010_0000, 8'h40);
        for (int k = 1; k < 8; k++) do_fill(40'h00_0010_0000 + ADDR_W'(k) * 40'h1000, ID_W'(8'h20 + k));
        count_hits(0, 8, hits);
        chk("R5", 64'(hits), 64'd8);
        expect_lk("R4", 40'h00_0010_0000, 1'b0, 1'b1, 8'h40);
        expect_lk("R5", 40'h00_0010_7000, 1'b0, 1'b1, 8'h27);

        // R6 R7: full buffer, new tag evicts exactly one (pseudo-random victim)
        do_fill(40'h00_0010_8000, 8'h88);
        expect_lk("R6", 40'h00_0010_8000, 1'b0, 1'b1, 8'h88);
        count_hits(0, 8, hits);
        chk("R6", 64'(hits), 64'd7);
        do_fill(40'h00_0010_9000, 8'h99);
        expect_lk("R7", 40'h00_0010_9000, 1'b0, 1'b1, 8'h99);
        count_hits(0, 9, hits);
        chk("R7", 64'(hits), 64'd7);

        // R8: fill coincident with flush is dropped
        @(negedge clk);
        fill_en = 1'b1; flush = 1'b1; fill_addr = 40'h00_0020_0000; fill_id = 8'h55;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        expect_lk("R8", 40'h00_0020_0000, 1'b0, 1'b0, 8'd0);
        count_hits(0, 10, hits);
        chk("R8", 64'(hits), 64'd0);

        // R9: direct-mapped index conflicts (index = tag[2:0])
        do_fill(40'h00_0000_3000, 8'd1);
        expect_lk("R9", 40'h00_0000_3000, 1'b1, 1'b1, 8'd1);
        do_fill(40'h00_0000_b000, 8'd2);
        expect_lk("R9", 40'h00_0000_3000, 1'b1, 1'b0, 8'd0);
        expect_lk("R9", 40'h00_0000_b000, 1'b1, 1'b1, 8'd2);
        do_fill(40'h00_0000_4000, 8'd3);
        expect_lk("R9", 40'h00_0000_b000, 1'b1, 1'b1, 8'd2);
        expect_lk("R9", 40'h00_0000_4000, 1'b1, 1'b1, 8'd3);
        // same stimulus in the associative build keeps both conflicting regions (R5)
        expect_lk("R5", 40'h00_0000_3000, 1'b0, 1'b1, 8'd1);
        probe(40'h0, 1'b0, h, i);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule